// File: doc/BRIEF.md
# Thread Context Fork Allocator

This block serves a request from a running hardware thread to start a new thread on a spare context of a small multithreaded core. It walks a bank of per-context state one context per clock, in ascending index order. It reads, for each context, the virtual-processor binding, the dynamic-allocation permission, the halt flag and the activated flag. It takes the first context that may be started. The walk covers only the contexts that the configuration says exist.

When a context is found, the block drives one write cycle into the bank. The write sets the new context's restart address and loads one of its general registers with a supplied value. It also rewrites the context's status, so that the context becomes active and dirty with a cleared run state and a cleared delay-slot flag. Privilege mode and address-space identifier are copied from the requester. When no context qualifies, the block instead writes an exception cause into the virtual-processor control state and raises a thread fault. Decode, the pipeline and the register storage itself lie outside the block. The block reaches the storage through a read-index port and a write strobe port.

Top module: `fork_alloc`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `ok`, `fault`, `wr_en` and `exc_wr_en` are all 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from then until the cycle after `done`. Operand inputs that change while the block is busy have no effect on the result.
- R3: The walk covers indices 0 to `cfg_last_ctx`, clamped to NCTX-1. `cfg_last_ctx` is sampled when the request is taken. A context above that limit is never chosen.
- R4: Contexts are examined in ascending index order. The lowest qualifying index is chosen, and `wr_idx` carries it.
- R5: A context qualifies only if four conditions all hold: its bound virtual-processor number equals `req_vpe`, its allocatable flag is 1, its halt flag is 0, and its activated flag is 0.
- R6: On success, `wr_restart` equals the `req_rs` taken with the request, `wr_gpr_addr` equals `req_rd`, and `wr_gpr_data` equals `req_rt`.
- R7: On success, the status written has run state 2'b00, delay-slot 0, dirty 1 and activated 1.
- R8: On success, `wr_ksu` equals the requester's `req_ksu` and `wr_asid` equals the requester's `req_asid`.
- R9: If no context qualifies, `fault` and `exc_wr_en` are 1 with `exc_code` equal to 1, and `ok` and `wr_en` are 0. On success, `ok` and `wr_en` are 1 and `fault` and `exc_wr_en` are 0.
- R10: The rising edge that takes the request counts as edge 1. `done` is high for exactly one cycle after edge k+2. Here k is the chosen index on success, or the clamped limit on failure.
- R11: While the walk is running, `wr_en` and `exc_wr_en` stay 0, so skipped contexts see no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fork request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vpe | input | VPEW | Requester's virtual-processor number |
| req_ksu | input | 2 | Requester's privilege mode from its global status |
| req_asid | input | ASIDW | Requester's address-space identifier |
| req_rs | input | AW | Restart address for the new context |
| req_rt | input | DW | Value for the new context's register |
| req_rd | input | RW | Register index in the new context |
| cfg_last_ctx | input | IDXW | Highest context index configured |
| bank_rd_idx | output | IDXW | Context being examined |
| bank_vpe | input | VPEW | Binding of the examined context |
| bank_da | input | 1 | Allocatable flag of the examined context |
| bank_halt | input | 1 | Halt flag of the examined context |
| bank_act | input | 1 | Activated flag of the examined context |
| wr_en | output | 1 | One-cycle write strobe into the chosen context |
| wr_idx | output | IDXW | Chosen context |
| wr_restart | output | AW | Restart address written |
| wr_gpr_addr | output | RW | Register index written |
| wr_gpr_data | output | DW | Register value written |
| wr_runst | output | 2 | Run state written |
| wr_dslot | output | 1 | Delay-slot flag written |
| wr_dirty | output | 1 | Dirty flag written |
| wr_act | output | 1 | Activated flag written |
| wr_ksu | output | 2 | Privilege mode written |
| wr_asid | output | ASIDW | Address-space identifier written |
| exc_wr_en | output | 1 | One-cycle write of the exception cause |
| exc_code | output | EXCW | Exception cause value |
| done | output | 1 | Request finished, one cycle |
| ok | output | 1 | A context was started |
| fault | output | 1 | Thread fault, no context available |

## Verification
The bench sweeps every mix of five per-context states over four contexts, and the configured limit varies along with the mix. The five states are: free, already active, halted, not allocatable, and bound elsewhere. The free state separates the search order from the qualification test. Each blocking state removes exactly one condition, so a fault in any single term of the test moves the chosen index or turns success into a fault. Because the limit varies, some free contexts lie above it, and these show whether the bound is honoured. Operands are changed mid-walk to show that they were captured at acceptance, and counting cycles to `done` ties latency to the chosen index.

// File: rtl/fork_pkg.sv
package fork_pkg;

   typedef enum logic [1:0] {
      FK_IDLE   = 2'd0,
      FK_SCAN   = 2'd1,
      FK_COMMIT = 2'd2,
      FK_FAIL   = 2'd3
   } fork_state_e;

   localparam logic [1:0] RUNST_RUNNING = 2'b00;
   localparam int unsigned CAUSE_NO_CTX = 1;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fork_match.sv
module fork_match #(
   parameter int unsigned VPEW = 2
) (
   input  logic [VPEW-1:0] own_vpe,
   input  logic [VPEW-1:0] cand_vpe,
   input  logic            cand_da,
   input  logic            cand_halt,
   input  logic            cand_act,
   output logic            qualifies
);

   logic same_vp;
   logic usable;

   always_comb begin
      same_vp   = (own_vpe == cand_vpe);
      usable    = cand_da && !cand_halt && !cand_act;
      qualifies = same_vp && usable;
   end

endmodule

// File: rtl/fork_fsm.sv
module fork_fsm
   import fork_pkg::*;
#(
   parameter int unsigned NCTX = 4,
   parameter int unsigned IDXW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [IDXW-1:0] cfg_last,
   input  logic            hit,
   output logic            req_ready,
   output logic            accept,
   output logic            scanning,
   output logic [IDXW-1:0] scan_idx,
   output logic            commit,
   output logic            fail
);

   localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NCTX - 1);

   fork_state_e     state_q;
   fork_state_e     state_d;
   logic [IDXW-1:0] idx_q;
   logic [IDXW-1:0] idx_d;
   logic [IDXW-1:0] last_q;
   logic [IDXW-1:0] last_eff;
   logic            at_last;

   generate
      if ((1 << IDXW) == NCTX) begin : g_full_range
         assign last_eff = cfg_last;
      end else begin : g_clamped
         assign last_eff = (cfg_last > TOP_IDX) ? TOP_IDX : cfg_last;
      end
   endgenerate

   assign req_ready = (state_q == FK_IDLE);
   assign accept    = req_ready && req_valid;
   assign scanning  = (state_q == FK_SCAN);
   assign commit    = (state_q == FK_COMMIT);
   assign fail      = (state_q == FK_FAIL);
   assign scan_idx  = idx_q;
   assign at_last   = (idx_q == last_q);

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      unique case (state_q)
         FK_IDLE: begin
            if (accept) begin
               state_d = FK_SCAN;
               idx_d   = '0;
            end
         end
         FK_SCAN: begin
            if (hit) begin
               state_d = FK_COMMIT;
            end else if (at_last) begin
               state_d = FK_FAIL;
            end else begin
               idx_d = idx_q + 1'b1;
            end
         end
         FK_COMMIT: state_d = FK_IDLE;
         FK_FAIL:   state_d = FK_IDLE;
         default:   state_d = FK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FK_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         if (accept) begin
            last_q <= last_eff;
         end
      end
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      scanning |-> (scan_idx <= last_q) && (scan_idx <= TOP_IDX)); // R3
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit || fail) |=> !(commit || fail)); // R10
   AST_COMMIT_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(scanning && hit)); // R5
   AST_FAIL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> $past(scanning && !hit && (scan_idx == last_q))); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready); // R2

endmodule

// File: rtl/fork_regs.sv
module fork_regs
   import fork_pkg::*;
#(
   parameter int unsigned IDXW  = 2,
   parameter int unsigned VPEW  = 2,
   parameter int unsigned ASIDW = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned RW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             scanning,
   input  logic             hit,
   input  logic [IDXW-1:0]  scan_idx,
   input  logic [VPEW-1:0]  in_vpe,
   input  logic [1:0]       in_ksu,
   input  logic [ASIDW-1:0] in_asid,
   input  logic [AW-1:0]    in_rs,
   input  logic [DW-1:0]    in_rt,
   input  logic [RW-1:0]    in_rd,
   output logic [VPEW-1:0]  own_vpe,
   output logic [IDXW-1:0]  chosen_idx,
   output logic [1:0]       own_ksu,
   output logic [ASIDW-1:0] own_asid,
   output logic [AW-1:0]    restart_addr,
   output logic [DW-1:0]    gpr_value,
   output logic [RW-1:0]    gpr_index
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vpe      <= '0;
         own_ksu      <= '0;
         own_asid     <= '0;
         restart_addr <= '0;
         gpr_value    <= '0;
         gpr_index    <= '0;
      end else if (accept) begin
         own_vpe      <= in_vpe;
         own_ksu      <= in_ksu;
         own_asid     <= in_asid;
         restart_addr <= in_rs;
         gpr_value    <= in_rt;
         gpr_index    <= in_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chosen_idx <= '0;
      end else if (scanning && hit) begin
         chosen_idx <= scan_idx;
      end
   end

   AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      scanning |=> $stable(restart_addr) && $stable(gpr_value) && $stable(own_asid)); // R2

endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
   import fork_pkg::*;
#(
   parameter  int unsigned NCTX  = 4,
   parameter  int unsigned VPEW  = 2,
   parameter  int unsigned ASIDW = 8,
   parameter  int unsigned AW    = 32,
   parameter  int unsigned DW    = 32,
   parameter  int unsigned RW    = 5,
   parameter  int unsigned EXCW  = 3,
   localparam int unsigned IDXW  = idx_width(NCTX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPEW-1:0]  req_vpe,
   input  logic [1:0]       req_ksu,
   input  logic [ASIDW-1:0] req_asid,
   input  logic [AW-1:0]    req_rs,
   input  logic [DW-1:0]    req_rt,
   input  logic [RW-1:0]    req_rd,
   input  logic [IDXW-1:0]  cfg_last_ctx,
   output logic [IDXW-1:0]  bank_rd_idx,
   input  logic [VPEW-1:0]  bank_vpe,
   input  logic             bank_da,
   input  logic             bank_halt,
   input  logic             bank_act,
   output logic             wr_en,
   output logic [IDXW-1:0]  wr_idx,
   output logic [AW-1:0]    wr_restart,
   output logic [RW-1:0]    wr_gpr_addr,
   output logic [DW-1:0]    wr_gpr_data,
   output logic [1:0]       wr_runst,
   output logic             wr_dslot,
   output logic             wr_dirty,
   output logic             wr_act,
   output logic [1:0]       wr_ksu,
   output logic [ASIDW-1:0] wr_asid,
   output logic             exc_wr_en,
   output logic [EXCW-1:0]  exc_code,
   output logic             done,
   output logic             ok,
   output logic             fault
);

   generate
      if (NCTX < 1) begin : g_bad_nctx
         $error("fork_alloc: NCTX must be at least 1");
      end
      if (VPEW < 1 || ASIDW < 1 || AW < 1 || DW < 1 || RW < 1) begin : g_bad_width
         $error("fork_alloc: all widths must be at least 1");
      end
      if (EXCW < 2) begin : g_bad_excw
         $error("fork_alloc: EXCW must hold the cause value");
      end
   endgenerate

   logic            accept;
   logic            scanning;
   logic            commit;
   logic            fail;
   logic            hit;
   logic [IDXW-1:0] scan_idx;
   logic [VPEW-1:0] own_vpe;

   fork_fsm #(
      .NCTX (NCTX),
      .IDXW (IDXW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .cfg_last  (cfg_last_ctx),
      .hit       (hit),
      .req_ready (req_ready),
      .accept    (accept),
      .scanning  (scanning),
      .scan_idx  (scan_idx),
      .commit    (commit),
      .fail      (fail)
   );

   fork_match #(
      .VPEW (VPEW)
   ) u_match (
      .own_vpe   (own_vpe),
      .cand_vpe  (bank_vpe),
      .cand_da   (bank_da),
      .cand_halt (bank_halt),
      .cand_act  (bank_act),
      .qualifies (hit)
   );

   fork_regs #(
      .IDXW  (IDXW),
      .VPEW  (VPEW),
      .ASIDW (ASIDW),
      .AW    (AW),
      .DW    (DW),
      .RW    (RW)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .scanning     (scanning),
      .hit          (hit),
      .scan_idx     (scan_idx),
      .in_vpe       (req_vpe),
      .in_ksu       (req_ksu),
      .in_asid      (req_asid),
      .in_rs        (req_rs),
      .in_rt        (req_rt),
      .in_rd        (req_rd),
      .own_vpe      (own_vpe),
      .chosen_idx   (wr_idx),
      .own_ksu      (wr_ksu),
      .own_asid     (wr_asid),
      .restart_addr (wr_restart),
      .gpr_value    (wr_gpr_data),
      .gpr_index    (wr_gpr_addr)
   );

   assign bank_rd_idx = scan_idx;
   assign wr_en       = commit;
   assign wr_runst    = RUNST_RUNNING;
   assign wr_dslot    = 1'b0;
   assign wr_dirty    = 1'b1;
   assign wr_act      = 1'b1;
   assign exc_wr_en   = fail;
   assign exc_code    = EXCW'(CAUSE_NO_CTX);
   assign done        = commit || fail;
   assign ok          = commit;
   assign fault       = fail;

   AST_OK_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok != fault)); // R9
   AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      exc_wr_en |-> !wr_en); // R9
   AST_QUIET_WHILE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready && !done |-> !wr_en && !exc_wr_en); // R11

endmodule

// File: tb/fork_alloc_bench.sv
module fork_alloc_bench;

   localparam int NCTX  = 4;
   localparam int IDXW  = 2;
   localparam int VPEW  = 2;
   localparam int ASIDW = 8;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int RW    = 5;
   localparam int EXCW  = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [VPEW-1:0]  req_vpe = '0;
   logic [1:0]       req_ksu = '0;
   logic [ASIDW-1:0] req_asid = '0;
   logic [AW-1:0]    req_rs = '0;
   logic [DW-1:0]    req_rt = '0;
   logic [RW-1:0]    req_rd = '0;
   logic [IDXW-1:0]  cfg_last_ctx = '0;
   logic [IDXW-1:0]  bank_rd_idx;
   logic [VPEW-1:0]  bank_vpe;
   logic             bank_da, bank_halt, bank_act;
   logic             wr_en, wr_dslot, wr_dirty, wr_act;
   logic [IDXW-1:0]  wr_idx;
   logic [AW-1:0]    wr_restart;
   logic [RW-1:0]    wr_gpr_addr;
   logic [DW-1:0]    wr_gpr_data;
   logic [1:0]       wr_runst, wr_ksu;
   logic [ASIDW-1:0] wr_asid;
   logic             exc_wr_en;
   logic [EXCW-1:0]  exc_code;
   logic             done, ok, fault;

   logic [VPEW-1:0] m_vpe  [NCTX];
   logic            m_da   [NCTX];
   logic            m_halt [NCTX];
   logic            m_act  [NCTX];

   assign bank_vpe  = m_vpe[bank_rd_idx];
   assign bank_da   = m_da[bank_rd_idx];
   assign bank_halt = m_halt[bank_rd_idx];
   assign bank_act  = m_act[bank_rd_idx];

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   fork_alloc u_fork_alloc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vpe(req_vpe), .req_ksu(req_ksu), .req_asid(req_asid),
      .req_rs(req_rs), .req_rt(req_rt), .req_rd(req_rd),
      .cfg_last_ctx(cfg_last_ctx), .bank_rd_idx(bank_rd_idx),
      .bank_vpe(bank_vpe), .bank_da(bank_da), .bank_halt(bank_halt),
      .bank_act(bank_act), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_restart(wr_restart), .wr_gpr_addr(wr_gpr_addr),
      .wr_gpr_data(wr_gpr_data), .wr_runst(wr_runst), .wr_dslot(wr_dslot),
      .wr_dirty(wr_dirty), .wr_act(wr_act), .wr_ksu(wr_ksu),
      .wr_asid(wr_asid), .exc_wr_en(exc_wr_en), .exc_code(exc_code),
      .done(done), .ok(ok), .fault(fault)
   );

   task automatic check(input bit cond, input string req,
                        input logic [63:0] actual, input logic [63:0] expected);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
      end
   endtask

   task automatic run_case(input int p);
      int pw;
      int code;
      int last;
      int exp_idx;
      int n;
      logic [AW-1:0]    rs0;
      logic [DW-1:0]    rt0;
      logic [RW-1:0]    rd0;
      logic [1:0]       ksu0;
      logic [ASIDW-1:0] asid0;
      logic [VPEW-1:0]  vpe0;
      last    = p % NCTX;
      vpe0    = VPEW'((p * 7) % 4);
      rs0     = 32'h1000_0000 + AW'(p * 4);
      rt0     = DW'(p * 3 + 5);
      rd0     = RW'(p % 32);
      ksu0    = 2'(p % 3);
      asid0   = ASIDW'(p * 11);
      exp_idx = -1;
      pw      = 1;
      for (int i = 0; i < NCTX; i++) begin
         code      = (p / pw) % 5;
         pw        = pw * 5;
         m_vpe[i]  = (code == 4) ? vpe0 + 1'b1 : vpe0;
         m_da[i]   = (code != 3);
         m_halt[i] = (code == 2);
         m_act[i]  = (code == 1);
         if (code == 0 && i <= last && exp_idx < 0) exp_idx = i;
      end
      @(negedge clk);
      check(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
      req_valid    = 1'b1;
      req_vpe      = vpe0;
      req_ksu      = ksu0;
      req_asid     = asid0;
      req_rs       = rs0;
      req_rt       = rt0;
      req_rd       = rd0;
      cfg_last_ctx = IDXW'(last);
      @(negedge clk);
      req_rs   = ~rs0;
      req_rt   = ~rt0;
      req_rd   = ~rd0;
      req_asid = ~asid0;
      req_ksu  = ~ksu0;
      n = 1;
      while (!done && n < 20) begin
         check(req_ready == 1'b0, "R2 busy", 64'(req_ready), 64'd0);
         check(!wr_en && !exc_wr_en, "R11 quiet walk", 64'({wr_en, exc_wr_en}), 64'd0);
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      check(n == ((exp_idx >= 0) ? exp_idx : last) + 2, "R10 latency",
            64'(n), 64'(((exp_idx >= 0) ? exp_idx : last) + 2));
      if (exp_idx >= 0) begin
         check(ok && !fault && wr_en && !exc_wr_en, "R9 success flags",
               64'({ok, fault, wr_en, exc_wr_en}), 64'b1010);
         check(wr_idx == IDXW'(exp_idx), "R4 R5 R3 chosen index",
               64'(wr_idx), 64'(exp_idx));
         check(wr_restart == rs0, "R6 restart", 64'(wr_restart), 64'(rs0));
         check(wr_gpr_addr == rd0 && wr_gpr_data == rt0, "R6 register load",
               64'({wr_gpr_addr, wr_gpr_data}), 64'({rd0, rt0}));
         check(wr_runst == 2'b00 && !wr_dslot && wr_dirty && wr_act, "R7 status",
               64'({wr_runst, wr_dslot, wr_dirty, wr_act}), 64'b00011);
         check(wr_ksu == ksu0 && wr_asid == asid0, "R8 inherited state",
               64'({wr_ksu, wr_asid}), 64'({ksu0, asid0}));
      end else begin
         check(fault && !ok && !wr_en && exc_wr_en, "R9 fault flags",
               64'({ok, fault, wr_en, exc_wr_en}), 64'b0101);
         check(exc_code == EXCW'(1), "R9 cause", 64'(exc_code), 64'd1);
      end
      @(negedge clk);
      check(!done, "R10 single pulse", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCTX; i++) begin
         m_vpe[i] = '0; m_da[i] = 1'b0; m_halt[i] = 1'b0; m_act[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      check(req_ready && !done && !ok && !fault && !wr_en && !exc_wr_en,
            "R1 reset state", 64'({req_ready, done, ok, fault, wr_en, exc_wr_en}),
            64'b100000);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !done && !wr_en && !exc_wr_en, "R1 after release",
            64'({req_ready, done, wr_en, exc_wr_en}), 64'b1000);
      for (int p = 0; p < 625; p++) begin
         run_case(p);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule